// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

This block is a bank of general-purpose pins. A narrow word-oriented register port reaches every register, and each pin has its own interrupt trigger. Through the port, software sets the driven level and direction of each pin and reads back a synchronised copy of the pin inputs. The same port configures how each pin raises an interrupt. All pins share one interrupt output.

Each register is one bit per pin and is reached at three addresses. A plain write replaces the register. A set write ORs the data in. A clear write removes the bits that are 1 in the data. Each pin has a mode bit and a polarity bit, which together pick one of four triggers. A sticky status bit latches the chosen condition, but only for pins whose routing bit is on. The interrupt output is high while any latched and enabled status bit is 1.

The design holds no state machine. The only enumerations are the alias operation, selected by address bits [3:2] (WRITE, SET, CLEAR, NONE), and the register selector in address bits [7:4]. Incoming pin values pass through a capture stage, then a stable stage, then a one-cycle history stage. Each register update is one transition from the old value to the new one.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every register is 0. pin_out and pin_oe are 0, irq is low, and every read returns 0.
- R2: A write at base+0x0 replaces the register. A write at base+0x4 ORs the data in. A write at base+0x8 clears the bits that are 1 in the data. Writes at base+0xC, writes with bus_addr[1:0] not 0, and writes to index 8 or above change nothing.
- R3: The register base is bus_addr[7:4]×0x10: 0 output data, 1 input view (read only), 2 output enable, 3 interrupt routing, 4 interrupt enable, 5 mode, 6 polarity, 7 status. A read returns the register at any of its alias addresses, and indexes 8 to 15 read 0.
- R4: pin_out equals the output-data register, and pin_oe equals the output-enable register (1 = drive).
- R5: The input view shows pin_in two clock edges after it is sampled. Writes to its addresses are ignored.
- R6: Mode/polarity select the trigger: mode 0/pol 0 falling edge, 0/1 rising edge, 1/0 low level, 1/1 high level. Each is judged on the synchronised pin, and the status bit rises one edge after the condition is seen.
- R7: In level mode the status bit is set again on every cycle the level persists. Once the level is gone, a clear removes the bit.
- R8: A status bit is set only if its routing bit is 1.
- R9: Status bits are cleared only by a clear write to 0x78. Plain writes (0x70) and set writes (0x74) to status are ignored.
- R10: When a set condition and a clear write hit the same status bit in one cycle, the bit stays 1.
- R11: irq is high exactly when some bit of status AND interrupt-enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | AW | Byte address: [7:4] register, [3:2] alias |
| bus_wdata | input | NPIN | Write data |
| bus_rdata | output | NPIN | Read data for bus_addr (combinational) |
| pin_in | input | NPIN | Asynchronous pin levels |
| pin_out | output | NPIN | Driven pin levels |
| pin_oe | output | NPIN | Per-pin drive enable |
| irq | output | 1 | Combined bank interrupt |

## Verification
Detection of a trigger condition and a clear write to status can land on the same status bit in the same edge. The bench provokes this by holding a pin at its active level in level mode and issuing a clear for that bit. The bench then reads status on the next cycle and expects the bit still set (R10). After the level is withdrawn, the same clear is expected to take effect (R7). A behavioural model in the bench keeps a history queue of the sampled pin values. Every clock, it compares the pins, the interrupt line and the read port against the design.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_SET   = 2'd1,
        OP_CLEAR = 2'd2,
        OP_NONE  = 2'd3
    } alias_op_e;

    typedef enum logic [2:0] {
        RS_DOUT  = 3'd0,
        RS_DIN   = 3'd1,
        RS_OE    = 3'd2,
        RS_ROUTE = 3'd3,
        RS_IEN   = 3'd4,
        RS_MODE  = 3'd5,
        RS_POL   = 3'd6,
        RS_STAT  = 3'd7
    } reg_sel_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] cur_o,
    output logic [W-1:0] prev_o
);
    logic [W-1:0] cap_q, cur_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q  <= '0;
            cur_q  <= '0;
            prev_q <= '0;
        end else begin
            cap_q  <= raw_i;
            cur_q  <= cap_q;
            prev_q <= cur_q;
        end
    end

    assign cur_o  = cur_q;
    assign prev_o = prev_q;
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect #(
    parameter int W = 32
) (
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] prev_i,
    input  logic [W-1:0] mode_i,
    input  logic [W-1:0] pol_i,
    output logic [W-1:0] hit_o
);
    for (genvar g = 0; g < W; g++) begin : g_pin
        logic rise, fall, lvl, edg;
        always_comb begin
            rise     = cur_i[g] & ~prev_i[g];
            fall     = ~cur_i[g] & prev_i[g];
            lvl      = pol_i[g] ? cur_i[g] : ~cur_i[g];
            edg      = pol_i[g] ? rise : fall;
            hit_o[g] = mode_i[g] ? lvl : edg;
        end
    end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_bank_pkg::*;
#(
    parameter int W  = 32,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [AW-1:0] addr_i,
    input  logic [W-1:0]  wdata_i,
    output logic [W-1:0]  rdata_o,
    input  logic [W-1:0]  din_i,
    input  logic [W-1:0]  hit_i,
    output logic [W-1:0]  dout_o,
    output logic [W-1:0]  oe_o,
    output logic [W-1:0]  route_o,
    output logic [W-1:0]  ien_o,
    output logic [W-1:0]  mode_o,
    output logic [W-1:0]  pol_o,
    output logic [W-1:0]  stat_o
);
    localparam int IDX_W = AW - 4;
    localparam int NREG  = 8;

    logic [IDX_W-1:0] idx;
    alias_op_e        op;
    reg_sel_e         sel;
    logic             in_map, wr_ok;

    logic [W-1:0] dout_q, oe_q, route_q, ien_q, mode_q, pol_q, stat_q;
    logic [W-1:0] stat_clr;

    assign idx    = addr_i[AW-1:4];
    assign op     = alias_op_e'(addr_i[3:2]);
    assign in_map = (idx < IDX_W'(NREG));
    assign sel    = reg_sel_e'(idx[2:0]);
    assign wr_ok  = wr_i && in_map && (addr_i[1:0] == 2'b00) && (op != OP_NONE);

    function automatic logic [W-1:0] apply(input alias_op_e o,
                                           input logic [W-1:0] old,
                                           input logic [W-1:0] d);
        unique case (o)
            OP_WRITE: apply = d;
            OP_SET:   apply = old | d;
            OP_CLEAR: apply = old & ~d;
            default:  apply = old;
        endcase
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q  <= '0;
            oe_q    <= '0;
            route_q <= '0;
            ien_q   <= '0;
            mode_q  <= '0;
            pol_q   <= '0;
        end else if (wr_ok) begin
            unique case (sel)
                RS_DOUT:  dout_q  <= apply(op, dout_q, wdata_i);
                RS_OE:    oe_q    <= apply(op, oe_q, wdata_i);
                RS_ROUTE: route_q <= apply(op, route_q, wdata_i);
                RS_IEN:   ien_q   <= apply(op, ien_q, wdata_i);
                RS_MODE:  mode_q  <= apply(op, mode_q, wdata_i);
                RS_POL:   pol_q   <= apply(op, pol_q, wdata_i);
                default:  ;
            endcase
        end
    end

    assign stat_clr = (wr_ok && sel == RS_STAT && op == OP_CLEAR) ? wdata_i : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~stat_clr) | (route_q & hit_i);
    end

    always_comb begin
        rdata_o = '0;
        if (in_map) begin
            unique case (sel)
                RS_DOUT:  rdata_o = dout_q;
                RS_DIN:   rdata_o = din_i;
                RS_OE:    rdata_o = oe_q;
                RS_ROUTE: rdata_o = route_q;
                RS_IEN:   rdata_o = ien_q;
                RS_MODE:  rdata_o = mode_q;
                RS_POL:   rdata_o = pol_q;
                RS_STAT:  rdata_o = stat_q;
            endcase
        end
    end

    assign dout_o  = dout_q;
    assign oe_o    = oe_q;
    assign route_o = route_q;
    assign ien_o   = ien_q;
    assign mode_o  = mode_q;
    assign pol_o   = pol_q;
    assign stat_o  = stat_q;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
    parameter int NPIN = 32,
    parameter int AW   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [NPIN-1:0] bus_wdata,
    output logic [NPIN-1:0] bus_rdata,
    input  logic [NPIN-1:0] pin_in,
    output logic [NPIN-1:0] pin_out,
    output logic [NPIN-1:0] pin_oe,
    output logic            irq
);
    logic [NPIN-1:0] cur_v, prev_v, hit_v;
    logic [NPIN-1:0] route_q, ien_q, mode_q, pol_q, stat_q;

    gpio_sync #(.W(NPIN)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw_i(pin_in),
        .cur_o(cur_v), .prev_o(prev_v)
    );

    gpio_detect #(.W(NPIN)) u_det (
        .cur_i(cur_v), .prev_i(prev_v), .mode_i(mode_q), .pol_i(pol_q),
        .hit_o(hit_v)
    );

    gpio_regs #(.W(NPIN), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(bus_wr), .addr_i(bus_addr),
        .wdata_i(bus_wdata), .rdata_o(bus_rdata), .din_i(cur_v),
        .hit_i(hit_v), .dout_o(pin_out), .oe_o(pin_oe),
        .route_o(route_q), .ien_o(ien_q), .mode_o(mode_q),
        .pol_o(pol_q), .stat_o(stat_q)
    );

    assign irq = |(stat_q & ien_q);
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
    parameter int NPIN = 32,
    parameter int AW   = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_wr,
    input logic [AW-1:0]   bus_addr,
    input logic [NPIN-1:0] pin_oe,
    input logic            irq,
    input logic [NPIN-1:0] stat,
    input logic [NPIN-1:0] ien,
    input logic [NPIN-1:0] route
);
    logic oe_wr, stat_clr_wr;
    assign oe_wr       = bus_wr && (bus_addr[AW-1:4] == (AW-4)'(2));
    assign stat_clr_wr = bus_wr && (bus_addr[AW-1:4] == (AW-4)'(7)) && (bus_addr[3:2] == 2'd2);

    assert_oe_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_wr |=> $stable(pin_oe));

    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_clr_wr |=> ((stat & $past(stat)) == $past(stat)));

    assert_route_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((stat & ~$past(stat) & ~$past(route)) == '0));

    assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == '0) |-> !irq);
endmodule

bind gpio_bank gpio_bank_chk #(.NPIN(NPIN), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .pin_oe(pin_oe), .irq(irq), .stat(stat_q), .ien(ien_q), .route(route_q)
);

// File: tb/sim_gpio_bank.sv
`timescale 1ns/1ps
module sim_gpio_bank;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_wr = 0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe;
    logic        irq;

    int total = 0, bad = 0, cyc = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    gpio_bank #(.NPIN(32), .AW(8)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // Behavioural reference model
    logic [31:0] m_dout, m_oe, m_route, m_ien, m_mode, m_pol, m_stat;
    logic [31:0] hist[$];
    logic [31:0] m_cur, m_prev, m_hit, m_clr;

    function automatic logic [31:0] upd(input logic [1:0] o, input logic [31:0] old, input logic [31:0] d);
        if (o == 2'd0) return d;
        if (o == 2'd1) return old | d;
        if (o == 2'd2) return old & ~d;
        return old;
    endfunction

    function automatic logic [31:0] m_din();
        return (hist.size() >= 2) ? hist[hist.size()-2] : 32'h0;
    endfunction

    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (a[7:4])
            4'd0: return m_dout;
            4'd1: return m_din();
            4'd2: return m_oe;
            4'd3: return m_route;
            4'd4: return m_ien;
            4'd5: return m_mode;
            4'd6: return m_pol;
            4'd7: return m_stat;
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_dout = 0; m_oe = 0; m_route = 0; m_ien = 0;
            m_mode = 0; m_pol = 0; m_stat = 0;
            hist.delete();
        end else begin
            m_cur  = (hist.size() >= 2) ? hist[hist.size()-2] : 32'h0;
            m_prev = (hist.size() >= 3) ? hist[hist.size()-3] : 32'h0;
            for (int i = 0; i < 32; i++) begin
                if (m_mode[i]) m_hit[i] = m_pol[i] ? m_cur[i] : !m_cur[i];
                else           m_hit[i] = m_pol[i] ? (m_cur[i] && !m_prev[i])
                                                   : (!m_cur[i] && m_prev[i]);
            end
            m_clr = (bus_wr && bus_addr == 8'h78) ? bus_wdata : 32'h0;
            m_stat = (m_stat & ~m_clr) | (m_route & m_hit);
            if (bus_wr && bus_addr[1:0] == 2'b00 && bus_addr[3:2] != 2'd3) begin
                case (bus_addr[7:4])
                    4'd0: m_dout  = upd(bus_addr[3:2], m_dout, bus_wdata);
                    4'd2: m_oe    = upd(bus_addr[3:2], m_oe, bus_wdata);
                    4'd3: m_route = upd(bus_addr[3:2], m_route, bus_wdata);
                    4'd4: m_ien   = upd(bus_addr[3:2], m_ien, bus_wdata);
                    4'd5: m_mode  = upd(bus_addr[3:2], m_mode, bus_wdata);
                    4'd6: m_pol   = upd(bus_addr[3:2], m_pol, bus_wdata);
                    default: ;
                endcase
            end
            hist.push_back(pin_in);
            if (hist.size() > 3) void'(hist.pop_front());
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Per-clock comparison against the model
    always @(posedge clk) begin
        #2;
        if (!done) begin
            check(rst_n ? "R4 pin_out" : "R1 pin_out", pin_out, m_dout);
            check(rst_n ? "R4 pin_oe"  : "R1 pin_oe",  pin_oe,  m_oe);
            check(rst_n ? "R11 irq"    : "R1 irq",     {31'h0, irq}, {31'h0, |(m_stat & m_ien)});
            check(rst_n ? "R3 rdata"   : "R1 rdata",   bus_rdata, m_read(bus_addr));
        end
    end

    task automatic bwr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0; bus_wdata = '0;
    endtask

    task automatic brd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected<%0d", cyc, 150000);
            summary();
        end
    end

    initial begin
        logic [31:0] v;
        waitn(4);
        rst_n = 1;
        waitn(1);
        check("R1 oe after reset", pin_oe, 32'h0);
        brd(8'h70, v); check("R1 status after reset", v, 32'h0);

        bwr(8'h00, 32'hA5A5_0000);
        bwr(8'h04, 32'h0000_00FF);
        bwr(8'h08, 32'hA000_0000);
        check("R2 alias sequence", pin_out, 32'h05A5_00FF);
        bwr(8'h0C, 32'hFFFF_FFFF);
        bwr(8'h01, 32'h0000_0000);
        check("R2 dead alias ignored", pin_out, 32'h05A5_00FF);
        bwr(8'h80, 32'hFFFF_FFFF);
        brd(8'h80, v); check("R3 unmapped reads zero", v, 32'h0);

        bwr(8'h20, 32'h0000_FFFF);
        bwr(8'h28, 32'h0000_000F);
        check("R4 output enable", pin_oe, 32'h0000_FFF0);

        @(negedge clk); pin_in = 32'h1234_5678;
        waitn(3);
        brd(8'h10, v); check("R5 input view", v, 32'h1234_5678);
        bwr(8'h10, 32'h0);
        brd(8'h14, v); check("R5 input write ignored", v, 32'h1234_5678);

        @(negedge clk); pin_in = 32'h6;
        waitn(4);
        bwr(8'h50, 32'h0000_000C);
        bwr(8'h60, 32'h0000_0019);
        bwr(8'h40, 32'hFFFF_FFFF);
        bwr(8'h30, 32'h0000_000F);
        waitn(2);
        brd(8'h70, v); check("R6 quiet pins no status", v, 32'h0);

        @(negedge clk); pin_in = 32'h7;
        waitn(4);
        brd(8'h70, v); check("R6 rising edge", v, 32'h1);
        check("R11 irq asserted", {31'h0, irq}, 32'h1);

        @(negedge clk); pin_in = 32'h5;
        waitn(4);
        brd(8'h70, v); check("R6 falling edge", v, 32'h3);

        @(negedge clk); pin_in = 32'h15;
        waitn(4);
        brd(8'h70, v); check("R8 unrouted pin", v, 32'h3);

        bwr(8'h70, 32'h0);
        bwr(8'h74, 32'hFFFF_FFFF);
        brd(8'h70, v); check("R9 plain/set ignored", v, 32'h3);
        bwr(8'h78, 32'h1);
        brd(8'h70, v); check("R9 clear alias", v, 32'h2);

        @(negedge clk); pin_in = 32'h11;
        waitn(4);
        brd(8'h70, v); check("R6 low level", v, 32'h6);
        bwr(8'h78, 32'h4);
        brd(8'h70, v); check("R10 set beats clear", v, 32'h6);
        @(negedge clk); pin_in = 32'h15;
        waitn(4);
        bwr(8'h78, 32'h4);
        brd(8'h70, v); check("R7 clear after level gone", v, 32'h2);

        @(negedge clk); pin_in = 32'h1D;
        waitn(4);
        brd(8'h70, v); check("R6 high level", v, 32'hA);

        bwr(8'h48, 32'hFFFF_FFFF);
        check("R11 irq masked", {31'h0, irq}, 32'h0);
        bwr(8'h44, 32'h2);
        check("R11 irq one enable", {31'h0, irq}, 32'h1);

        @(negedge clk); pin_in = 32'h15;
        waitn(4);
        bwr(8'h78, 32'hFFFF_FFFF);
        brd(8'h70, v); check("R9 clear all", v, 32'h0);
        check("R11 irq after clear", {31'h0, irq}, 32'h0);

        waitn(3);
        summary();
    end
endmodule